// File: doc/BRIEF.md
# Square-Wave Clock Divider Channel

This block is a single timer channel that turns a count clock into a continuous square wave. The period of the wave is a programmed number of count clocks, N. Software, or a neighbouring block, writes N as a parallel word and pulses a load strobe. When N is even, the wave spends equal time high and low. When N is odd, the high phase is one count clock longer than the low phase.

The channel holds an internal counting element that steps down by two on each falling edge of the count clock. The element is reloaded at each phase change. For odd N the reload value is N-1. The phase boundary then falls on a different count value in the high phase than in the low phase, and this produces the uneven split without a second reload value.

A gate input pauses the channel. While the gate is low, the output is held high. When the gate returns high, the channel starts again with a fresh high phase. An asynchronous active-low reset returns the channel to idle. In the idle state the output is high and nothing counts.

Top module: `sqwave_div`

## Requirements
- R1: On a falling edge of `clk` with `load_stb` high, the channel captures `load_val` as N and sets the output high. This happens even in the middle of a count. The counting element is loaded on the next falling edge on which `gate` is high, and that loading edge does not decrement it.
- R2: For odd N of 3 or more, the output stays high for (N+1)/2 count clocks, including the clock that starts at the loading edge. It then stays low for (N-1)/2 count clocks, and this pattern repeats with no limit.
- R3: Once loaded, the counting element always holds an even value. Away from a reload, it decreases by exactly 2 per count clock. The reload value is N-1 for odd N and N for even N.
- R4: For even N, the output is high for N/2 count clocks and low for N/2 count clocks, starting with the high phase at the loading edge.
- R5: A programmed value of 0 acts as 65536. The first high phase lasts 32768 count clocks, and the next low phase lasts 32768 count clocks.
- R6: A programmed value of 1 leaves the output high for as long as that value stays programmed.
- R7: While `gate` is low, `wave_out` is high without waiting for a clock edge, and counting is frozen. On the first falling edge with `gate` high again, the element is reloaded and a full high phase begins.
- R8: After `rst_n` is asserted, `wave_out` is high. Until a value is programmed, it stays high whatever `gate` does.
- R9: Writing a new N while the channel is counting drops the old count. The new period applies from the next falling edge, starting with a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | High enables counting; low pauses and forces the output high |
| load_stb | input | 1 | Load strobe for `load_val`, sampled on the falling edge of `clk` |
| load_val | input | 16 | Period N in count clocks; 0 means 65536 |
| wave_out | output | 1 | Square-wave output |

## Verification
The bench sweeps every N from 1 to 40 and also checks N = 65535 and N = 0. For each N it predicts the output level of every count clock from the phase arithmetic alone. A design that used the same reload value and boundary for both phases would give a symmetric wave for odd N, or a period one clock off, and this shows up within the first cycle of the wave. The load edge is also checked: a design that decremented on the loading edge would bring the first falling edge of the output one clock early. The N = 1 and N = 0 cases catch an underflow in the low phase and a truncated 65536 count. Separate runs cover a gate drop, a reprogram while the output is low, and a reset in the middle of a run. These catch an output that does not go high at once, or a count that resumes where it stopped instead of starting a fresh high phase.

// File: rtl/sqwave_div.sv
module sqwave_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         load_stb,
  input  logic [W-1:0] load_val,
  output logic         wave_out
);
  localparam int CW = W + 1;

  logic [W-1:0]  n_q;
  logic [CW-1:0] ce_q;
  logic          armed_q;
  logic          pend_q;
  logic          phase_q;

  wire           odd    = n_q[0];
  wire           is_one = (n_q == W'(1));
  wire [CW-1:0]  n_ext  = (n_q == '0) ? (CW'(1) << W) : {1'b0, n_q};
  wire [CW-1:0]  reload = odd ? (n_ext - CW'(1)) : n_ext;
  wire           hit    = (odd && phase_q) ? (ce_q == '0) : (ce_q == CW'(2));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      ce_q    <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      phase_q <= 1'b1;
    end else if (load_stb) begin
      n_q     <= load_val;
      armed_q <= 1'b1;
      pend_q  <= 1'b1;
      phase_q <= 1'b1;
    end else if (armed_q) begin
      if (!gate) begin
        pend_q  <= 1'b1;
        phase_q <= 1'b1;
      end else if (pend_q) begin
        ce_q   <= reload;
        pend_q <= 1'b0;
      end else if (hit) begin
        if (!is_one) phase_q <= ~phase_q;
        ce_q <= reload;
      end else begin
        ce_q <= ce_q - CW'(2);
      end
    end
  end

  assign wave_out = phase_q | ~gate;

  AST_LOAD_SETS_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
    load_stb |=> phase_q); // R1

  AST_CE_EVEN: assert property (@(negedge clk) disable iff (!rst_n)
    (armed_q && !pend_q) |-> !ce_q[0]); // R3

  AST_STEP_TWO: assert property (@(negedge clk) disable iff (!rst_n)
    (armed_q && !pend_q && gate && !load_stb && ce_q > CW'(2)) |=> (ce_q == $past(ce_q) - CW'(2))); // R3

  AST_LOW_FLOOR: assert property (@(negedge clk) disable iff (!rst_n)
    !phase_q |-> (ce_q >= CW'(2))); // R2

  AST_ONE_STAYS_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
    (armed_q && is_one) |-> phase_q); // R6

  AST_GATE_FREEZE: assert property (@(negedge clk) disable iff (!rst_n)
    (!gate && !load_stb) |=> (phase_q && $stable(ce_q))); // R7

  AST_IDLE_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
    !armed_q |-> phase_q); // R8
endmodule

// File: tb/sqwave_div_tb_top.sv
module sqwave_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b1;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic        wave_out;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  sqwave_div #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate(gate),
    .load_stb(load_stb), .load_val(load_val), .wave_out(wave_out)
  );

  task automatic chk(input logic exp, input string req, input int idx);
    n_cmp++;
    if (wave_out !== exp) begin
      n_bad++;
      $display("FAIL %s idx=%0d actual=%b expected=%b", req, idx, wave_out, exp);
    end
  endtask

  function automatic logic exp_level(input int neff, input int k);
    int h;
    if (neff == 1) return 1'b1;
    h = (neff % 2 == 1) ? (neff + 1) / 2 : neff / 2;
    return ((k % neff) < h);
  endfunction

  task automatic program_n(input logic [15:0] n);
    @(posedge clk);
    load_val = n;
    load_stb = 1'b1;
    @(posedge clk);
    load_stb = 1'b0;
    chk(1'b1, "R1", -1);
  endtask

  task automatic run_chk(input int neff, input int cycles, input string req);
    for (int j = 1; j <= cycles; j++) begin
      @(posedge clk);
      chk(exp_level(neff, j - 1), req, j);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk(1'b1, "R8", 0);
    rst_n = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(posedge clk);
      gate = j[1];
      #1 chk(1'b1, "R8", j);
    end
    gate = 1'b1;

    for (int n = 1; n <= 40; n++) begin
      program_n(16'(n));
      run_chk(n, 3 * n + 2, (n == 1) ? "R6" : ((n % 2 == 1) ? "R2" : "R4"));
    end

    program_n(16'd65535);
    run_chk(65535, 32770, "R2");
    program_n(16'd0);
    run_chk(65536, 32772, "R5");

    program_n(16'd7);
    run_chk(7, 9, "R7");
    @(posedge clk);
    gate = 1'b0;
    #1 chk(1'b1, "R7", 0);
    for (int j = 0; j < 6; j++) begin
      @(posedge clk);
      chk(1'b1, "R7", j);
    end
    gate = 1'b1;
    chk(1'b1, "R7", 99);
    run_chk(7, 16, "R7");

    program_n(16'd9);
    run_chk(9, 7, "R9");
    chk(1'b0, "R9", 100);
    program_n(16'd4);
    run_chk(4, 12, "R9");
    program_n(16'd3);
    run_chk(3, 10, "R3");

    program_n(16'd6);
    run_chk(6, 4, "R8");
    @(posedge clk);
    rst_n = 1'b0;
    #1 chk(1'b1, "R8", 200);
    @(posedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 20; j++) begin
      @(posedge clk);
      chk(1'b1, "R8", 300 + j);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule